// File: doc/BRIEF.md
# Machine-Check Error Logging Bank

This block is one error-reporting bank. Error reporters hand it one event at a time through a set of event inputs. Each event carries:
- a 16-bit type code and a 16-bit detail field
- a severity (corrected or uncorrected)
- an index that picks a bit in the bank's enable control register
- context-corrupt, address-present and misc-present qualifiers
- 64-bit address and misc payloads

The bank decides whether the event replaces the entry already held. It keeps sticky valid and overflow flags and counts corrected events in a saturating field of the status word.

Software reaches four 64-bit registers through a plain register port with a combinational read and a single-cycle write. Writing the status register is the only way to clear the valid and overflow flags. Two outputs decode the logged type code, so that the internal-error and cache-tag-error classes can be routed without reading the register.

Top module: `mc_log_bank`

## Requirements
- R1: After reset, the control, status, address and misc registers read as zero, and both decode outputs are low.
- R2: An event that is written into an empty bank (status bit 63 clear) produces this status layout: bit 63 = 1, bits [15:0] = type code, bits [31:16] = detail field, bit 61 = 1 for uncorrected.
- R3: Every event that arrives while bit 63 is set sets overflow bit 62, whether or not the event is written. Only a software write clears bit 62. Only a software write clears bit 63.
- R4: An uncorrected event replaces a held corrected entry.
- R5: A held uncorrected entry is never replaced. A corrected event never replaces a held corrected entry. In both cases only bit 62 and the count change.
- R6: Bit 57 (context corrupt) is 1 for every logged uncorrected event. For a corrected event it copies the reporter's context-corrupt input.
- R7: Bit 60 (enabled) equals control bit `evt_sel` for a logged uncorrected event. It is 0 for a logged corrected event.
- R8: Bits 58 and 59 record whether the address and misc payloads belong to the logged event. A read of the address (sw_addr 2) or misc (sw_addr 3) register returns zero while the matching bit is clear. Control is at sw_addr 0 and status at sw_addr 1.
- R9: The count in bits [52:38] increments on every corrected event, whether written or not. It stops at 0x7FFF. It becomes zero when software writes status with bit 63 clear.
- R10: When a software write and an event fall in the same cycle, the write is applied first and the event is applied to its result.
- R11: `log_internal` is high when bit 63 is set and the code is 0x0400. `log_l3tag` is high when bit 63 is set and the code is 0x010B.
- R12: The control register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | Event present this cycle |
| evt_code | input | 16 | Error type code |
| evt_detail | input | 16 | Model-specific detail |
| evt_uncorr | input | 1 | 1 = uncorrected, 0 = corrected |
| evt_sel | input | 6 | Control bit index giving the enable |
| evt_pcc | input | 1 | Reporter's context-corrupt qualifier |
| evt_addrv | input | 1 | Address payload is meaningful |
| evt_miscv | input | 1 | Misc payload is meaningful |
| evt_addr | input | 64 | Address payload |
| evt_misc | input | 64 | Misc payload |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 2 | Register select: 0 control, 1 status, 2 address, 3 misc |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Software read data |
| log_internal | output | 1 | Valid entry holds the internal-error code |
| log_l3tag | output | 1 | Valid entry holds the cache-tag-error code |

## Verification
The bench runs a chain of events in which each entry builds on the previous one. A design that ranks the events wrongly would let a corrected event or a second uncorrected event overwrite the held code. A design that sets overflow only on a write would miss bit 62 on rejected events.

Directed cases cover the following:
- a clear and an event in the same cycle, where the wrong order shows a lost event or a false overflow
- a count driven to its limit, which would wrap to zero without saturation
- an address-valid/misc-valid pair that exposes unmasked reads
- an enable bit that tells a design copying the wrong source for bit 60

// File: rtl/mc_log_bank.sv
module mc_log_bank #(
  parameter int N_EN = 64,
  localparam int SEL_W = $clog2(N_EN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [15:0]      evt_code,
  input  logic [15:0]      evt_detail,
  input  logic             evt_uncorr,
  input  logic [SEL_W-1:0] evt_sel,
  input  logic             evt_pcc,
  input  logic             evt_addrv,
  input  logic             evt_miscv,
  input  logic [63:0]      evt_addr,
  input  logic [63:0]      evt_misc,
  input  logic             sw_we,
  input  logic [1:0]       sw_addr,
  input  logic [63:0]      sw_wdata,
  output logic [63:0]      sw_rdata,
  output logic             log_internal,
  output logic             log_l3tag
);
  localparam int CNT_LO = 38;
  localparam int CNT_HI = 52;
  localparam int CNT_W  = CNT_HI - CNT_LO + 1;

  logic [N_EN-1:0]  ctl;
  logic [63:0]      st, addr_q, misc_q;
  logic [63:0]      st_base, st_nx;
  logic [CNT_W-1:0] cnt;
  logic             take;

  wire wr_ctl  = sw_we && sw_addr == 2'd0;
  wire wr_st   = sw_we && sw_addr == 2'd1;
  wire wr_addr = sw_we && sw_addr == 2'd2;
  wire wr_misc = sw_we && sw_addr == 2'd3;

  always_comb begin
    st_base = st;
    if (wr_st) begin
      st_base = sw_wdata;
      if (!sw_wdata[63]) st_base[CNT_HI:CNT_LO] = '0;
    end
    st_nx = st_base;
    cnt   = st_base[CNT_HI:CNT_LO];
    take  = 1'b0;
    if (evt_valid) begin
      if (!evt_uncorr && cnt != '1) cnt = cnt + CNT_W'(1);
      take = !st_base[63] || (evt_uncorr && !st_base[61]);
      if (take) begin
        st_nx          = '0;
        st_nx[15:0]    = evt_code;
        st_nx[31:16]   = evt_detail;
        st_nx[63]      = 1'b1;
        st_nx[61]      = evt_uncorr;
        st_nx[60]      = evt_uncorr && ctl[evt_sel];
        st_nx[59]      = evt_miscv;
        st_nx[58]      = evt_addrv;
        st_nx[57]      = evt_uncorr || evt_pcc;
      end
      st_nx[62] = st_base[62] | st_base[63];
      st_nx[CNT_HI:CNT_LO] = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      st     <= '0;
      addr_q <= '0;
      misc_q <= '0;
    end else begin
      st <= st_nx;
      if (wr_ctl) ctl <= sw_wdata[N_EN-1:0];
      if (take) addr_q <= evt_addr;
      else if (wr_addr) addr_q <= sw_wdata;
      if (take) misc_q <= evt_misc;
      else if (wr_misc) misc_q <= sw_wdata;
    end
  end

  always_comb begin
    unique case (sw_addr)
      2'd0: sw_rdata = 64'(ctl);
      2'd1: sw_rdata = st;
      2'd2: sw_rdata = st[58] ? addr_q : '0;
      default: sw_rdata = st[59] ? misc_q : '0;
    endcase
  end

  assign log_internal = st[63] && st[15:0] == 16'h0400;
  assign log_l3tag    = st[63] && st[15:0] == 16'h010B;

  // R2
  uc_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_uncorr && !st[63] && !sw_we) |=> (st[63] && st[61] && st[57]));
  // R3
  over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && st[63] && !sw_we) |=> st[62]);
  // R3
  val_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[63] && !sw_we) |=> st[63]);
  // R5
  uc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && st[63] && st[61] && !sw_we) |=> $stable(st[31:0]));
  // R5
  corr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_uncorr && st[63] && !sw_we) |=> $stable(st[31:0]));
  // R7
  corr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_uncorr && !st[63] && !sw_we) |=> (!st[60] && !st[61]));
endmodule

// File: tb/test_mc_log_bank.sv
`timescale 1ns/1ps
module test_mc_log_bank;
  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_uncorr = 0, evt_pcc = 0, evt_addrv = 0, evt_miscv = 0;
  logic [15:0] evt_code = 0, evt_detail = 0;
  logic [5:0]  evt_sel = 0;
  logic [63:0] evt_addr = 0, evt_misc = 0, sw_wdata = 0, sw_rdata;
  logic sw_we = 0;
  logic [1:0] sw_addr = 0;
  logic log_internal, log_l3tag;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mc_log_bank i_mc_log_bank (.*);

  // {clr, uc, pcc, sel[5:0], code[15:0], exp flags[63:57], exp code, exp count}
  localparam logic [62:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b1, 6'd0, 16'h010B, 7'h41, 16'h010B, 15'd1},
    {1'b0, 1'b0, 1'b0, 6'd0, 16'h0400, 7'h61, 16'h010B, 15'd2},
    {1'b0, 1'b1, 1'b0, 6'd0, 16'h0400, 7'h71, 16'h0400, 15'd2},
    {1'b0, 1'b1, 1'b0, 6'd1, 16'h0111, 7'h71, 16'h0400, 15'd2},
    {1'b1, 1'b1, 1'b0, 6'd1, 16'h0111, 7'h59, 16'h0111, 15'd0},
    {1'b0, 1'b0, 1'b0, 6'd0, 16'h0222, 7'h79, 16'h0111, 15'd1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    sw_addr = a;
    #1 d = sw_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); sw_we = 1; sw_addr = a; sw_wdata = d;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic ev(input logic uc, input logic pcc, input logic av, input logic mv,
                    input logic [5:0] sel, input logic [15:0] code, input logic [15:0] det,
                    input logic [63:0] a, input logic [63:0] m);
    @(negedge clk);
    evt_valid = 1; evt_uncorr = uc; evt_pcc = pcc; evt_addrv = av; evt_miscv = mv;
    evt_sel = sel; evt_code = code; evt_detail = det; evt_addr = a; evt_misc = m;
    @(negedge clk); evt_valid = 0;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 ctl", d, 0);
    rd(2'd1, d); chk("R1 status", d, 0);
    chk("R1 decode", {log_internal, log_l3tag}, 0);
    rst_n = 1;
    rd(2'd2, d); chk("R1 addr", d, 0);

    // R12 control readback
    wr(2'd0, 64'h2);
    rd(2'd0, d); chk("R12 ctl", d, 64'h2);

    // table walk: R3 R4 R5 R6 R7 R9
    foreach (VEC[i]) begin
      if (VEC[i][62]) wr(2'd1, 64'h0);
      ev(VEC[i][61], VEC[i][60], 1'b0, 1'b0, VEC[i][59:54], VEC[i][53:38],
         16'h0, 64'h0, 64'h0);
      rd(2'd1, d);
      chk($sformatf("R4/R5/R6/R7 flags vec%0d", i), 64'(d[63:57]), 64'(VEC[i][37:31]));
      chk($sformatf("R5 code vec%0d", i), 64'(d[15:0]), 64'(VEC[i][30:15]));
      chk($sformatf("R9 count vec%0d", i), 64'(d[52:38]), 64'(VEC[i][14:0]));
    end

    // R8 masking, R2 detail, R11 decode
    wr(2'd1, 64'h0);
    ev(1'b1, 1'b0, 1'b1, 1'b0, 6'd0, 16'h010B, 16'h1234, 64'hAAA, 64'h55);
    rd(2'd2, d); chk("R8 addr visible", d, 64'hAAA);
    rd(2'd3, d); chk("R8 misc masked", d, 0);
    rd(2'd1, d);
    chk("R8 flags", 64'(d[63:57]), 64'h53);
    chk("R2 detail", 64'(d[31:16]), 64'h1234);
    chk("R11 decode l3tag", {log_internal, log_l3tag}, 64'b01);
    wr(2'd1, 64'h0);
    ev(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 16'h0400, 16'h0, 64'h0, 64'h77);
    rd(2'd3, d); chk("R8 misc visible", d, 64'h77);
    rd(2'd2, d); chk("R8 addr masked", d, 0);
    chk("R11 decode internal", {log_internal, log_l3tag}, 64'b10);

    // R9 saturation
    wr(2'd1, {1'b1, 10'b0, 15'h7FFE, 38'b0});
    ev(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 16'h0001, 16'h0, 64'h0, 64'h0);
    ev(1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 16'h0001, 16'h0, 64'h0, 64'h0);
    rd(2'd1, d);
    chk("R9 saturate", 64'(d[52:38]), 64'h7FFF);
    chk("R3 overflow on reject", 64'(d[62]), 1);

    // R10 write and event together
    @(negedge clk);
    sw_we = 1; sw_addr = 2'd1; sw_wdata = 64'h0;
    evt_valid = 1; evt_uncorr = 0; evt_pcc = 0; evt_addrv = 0; evt_miscv = 0;
    evt_code = 16'h0333; evt_detail = 16'h0;
    @(negedge clk); sw_we = 0; evt_valid = 0;
    rd(2'd1, d);
    chk("R10 flags", 64'(d[63:57]), 64'h40);
    chk("R10 code", 64'(d[15:0]), 64'h0333);
    chk("R10 count", 64'(d[52:38]), 64'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule